// File: doc/BRIEF.md
# Stalled-Stream Timeout Timer

This block watches the outbound stream of a memory-read DMA channel and reports when the downstream sink holds the channel stalled for too long. Each time the channel attempts to move data, it pulses `svc_try`. On that pulse the timer stops. It re-arms only when three things hold at once: timeouts are enabled, a transfer is still pending, and the sink is not ready.

Once armed, a prescaler divides the clock by `presc_div + 1`. A one-shot down-counter loaded from `tmo_count` steps down on each prescaler tick. At expiry the block emits a single-cycle `tmo_pulse`, but only if the enable is still set in that cycle. The counter never reloads by itself. The field values come from register storage outside the block. They are captured when the timer arms.

No data flows through the block. `sink_ready` is observed only as the ready half of the stream handshake, and the block never drives back-pressure. Every pin is a plain control or status level.

Top module: `stall_timeout_timer`

## Requirements
- R1: After reset the timer is idle and `tmo_pulse` is low.
- R2: A `svc_try` pulse arms the timer only when `tmo_en`=1, `xfer_pending`=1 and `sink_ready`=0 in that cycle; otherwise no pulse follows.
- R3: While armed, a prescaler tick occurs every `presc_div`+1 clocks, counted afresh from the arming edge.
- R4: With count C>=1, `tmo_pulse` is high in the cycle after clock edge a+(P+1)*C, where a is the arming edge and P is `presc_div`.
- R5: A count of zero expires on the first prescaler tick, at edge a+(P+1).
- R6: The pulse lasts exactly one cycle. The timer is one-shot: after expiry no further pulse occurs without a new arming.
- R7: A new `svc_try` restarts both counters from scratch. If the arming conditions fail, it stops the timer.
- R8: If `tmo_en` is 0 at the expiry edge, the pulse is suppressed and the timer still ends.
- R9: A `svc_try` in the same cycle as expiry takes precedence. No pulse occurs, and the timer re-arms if the conditions hold.
- R10: `tmo_count` and `presc_div` are captured at arming. Later changes have no effect on the running timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmo_en | input | 1 | Timeout enable field |
| tmo_count | input | CNT_W | Down-counter load value |
| presc_div | input | PRE_W | Prescaler divisor minus one |
| svc_try | input | 1 | Channel attempted to move data this cycle |
| xfer_pending | input | 1 | Remaining transfer size is non-zero |
| sink_ready | input | 1 | Stream sink can accept data |
| tmo_pulse | output | 1 | Single-cycle stream-timeout event |

## Verification
Expiry and a service attempt can land on the same clock edge. The bench provokes this by arming with a short count and issuing `svc_try` exactly on the computed expiry edge. It then expects silence at the old expiry and a pulse one full period after the new arming. Enable removal at expiry is a second case of this kind. The bench drops `tmo_en` before the computed expiry edge, then expects no pulse ever, even after the enable returns.

// File: rtl/stt_pkg.sv
`timescale 1ns/1ps
package stt_pkg;
  typedef enum logic {
    TMR_IDLE  = 1'b0,
    TMR_COUNT = 1'b1
  } tmr_state_e;
endpackage

// File: rtl/stt_prescaler.sv
`timescale 1ns/1ps
module stt_prescaler #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [PRE_W-1:0] div_in,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] lim_q;

  // restart and capture the divisor on every service attempt
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
      lim_q <= div_in;
    end else if (run) begin
      if (cnt_q == lim_q) cnt_q <= '0;
      else                cnt_q <= cnt_q + PRE_W'(1);
    end
  end

  assign tick = run && !clear && (cnt_q == lim_q);
endmodule

// File: rtl/stt_downcount.sv
`timescale 1ns/1ps
module stt_downcount #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  // a count of one or zero ends on the current tick
  assign expire = tick && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load)             cnt_q <= load_val;
    else if (tick && !expire)  cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/stt_arm_ctl.sv
`timescale 1ns/1ps
module stt_arm_ctl
  import stt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic service,
  input  logic enable,
  input  logic pending,
  input  logic sink_ready,
  input  logic expire,
  output logic arm,
  output logic running,
  output logic pulse
);
  tmr_state_e st_q;
  logic       pulse_q;

  assign arm = service && enable && pending && !sink_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= TMR_IDLE;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (service) begin
        st_q <= arm ? TMR_COUNT : TMR_IDLE;
      end else if (expire) begin
        st_q    <= TMR_IDLE;
        pulse_q <= enable;
      end
    end
  end

  assign running = (st_q == TMR_COUNT);
  assign pulse   = pulse_q;
endmodule

// File: rtl/stall_timeout_timer.sv
`timescale 1ns/1ps
module stall_timeout_timer #(
  parameter int CNT_W = 12,
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmo_en,
  input  logic [CNT_W-1:0] tmo_count,
  input  logic [PRE_W-1:0] presc_div,
  input  logic             svc_try,
  input  logic             xfer_pending,
  input  logic             sink_ready,
  output logic             tmo_pulse
);
  logic arm_w;
  logic run_w;
  logic tick_w;
  logic expire_w;

  stt_arm_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .service(svc_try), .enable(tmo_en),
    .pending(xfer_pending), .sink_ready(sink_ready), .expire(expire_w),
    .arm(arm_w), .running(run_w), .pulse(tmo_pulse)
  );

  stt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(svc_try), .run(run_w),
    .div_in(presc_div), .tick(tick_w)
  );

  stt_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(arm_w), .load_val(tmo_count),
    .tick(tick_w), .expire(expire_w)
  );
endmodule

// File: rtl/stall_timeout_timer_chk.sv
`timescale 1ns/1ps
module stall_timeout_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic svc,
  input logic en,
  input logic pend,
  input logic rdy,
  input logic run,
  input logic pulse
);
  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
  // R6
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> !run);
  // R4
  pulse_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(run));
  // R8
  pulse_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(en));
  // R9
  service_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc |=> !pulse);
  // R2
  no_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc && !(en && pend && !rdy)) |=> !run);
endmodule

bind stall_timeout_timer stall_timeout_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .svc(svc_try), .en(tmo_en), .pend(xfer_pending),
  .rdy(sink_ready), .run(run_w), .pulse(tmo_pulse)
);

// File: tb/stall_timeout_timer_tb.sv
`timescale 1ns/1ps
module stall_timeout_timer_tb;
  localparam int CW = 12;
  localparam int PW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tmo_en = 1'b0;
  logic [CW-1:0] tmo_count = '0;
  logic [PW-1:0] presc_div = '0;
  logic svc_try = 1'b0;
  logic xfer_pending = 1'b0;
  logic sink_ready = 1'b0;
  logic tmo_pulse;

  always #2.5 clk = ~clk;

  stall_timeout_timer #(.CNT_W(CW), .PRE_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tmo_en(tmo_en), .tmo_count(tmo_count),
    .presc_div(presc_div), .svc_try(svc_try), .xfer_pending(xfer_pending),
    .sink_ready(sink_ready), .tmo_pulse(tmo_pulse)
  );

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int exp_q[$];
  string cur_req = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare pulses with the scoreboard queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (tmo_pulse) begin
        checks++;
        if (exp_q.size() > 0 && exp_q[0] == cyc) begin
          void'(exp_q.pop_front());
        end else begin
          errors++;
          $display("FAIL %s: pulse at cycle %0d actual=1 expected=0", cur_req, cyc);
        end
      end else if (exp_q.size() > 0 && exp_q[0] == cyc) begin
        checks++;
        errors++;
        $display("FAIL %s: missing pulse at cycle %0d actual=0 expected=1", cur_req, cyc);
        void'(exp_q.pop_front());
      end
    end
  end

  // driver: one service attempt; pushes the expected pulse cycle if it arms
  task automatic service(input bit en, input bit pend, input bit rdy,
                         input int c, input int p);
    int a;
    @(negedge clk);
    tmo_en = en; xfer_pending = pend; sink_ready = rdy;
    tmo_count = CW'(c); presc_div = PW'(p);
    svc_try = 1'b1;
    a = cyc + 1;
    exp_q.delete();
    if (en && pend && !rdy) exp_q.push_back(a + (p + 1) * ((c == 0) ? 1 : c));
    @(negedge clk);
    svc_try = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drained(input string req);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s: pending expectations actual=%0d expected=0", req, exp_q.size());
    end
    exp_q.delete();
  endtask

  bit timed_out = 1'b0;

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int i = 0; i < 5; i++) begin
          @(negedge clk);
          checks++;
          if (tmo_pulse !== 1'b0) begin
            errors++;
            $display("FAIL R1: pulse after reset actual=%b expected=0", tmo_pulse);
          end
        end
        // R4 R3 basic
        cur_req = "R4"; service(1, 1, 0, 3, 2); idle(20); drained("R4");
        cur_req = "R3"; service(1, 1, 0, 2, 5); idle(20); drained("R3");
        // R5 zero count
        cur_req = "R5"; service(1, 1, 0, 0, 0); idle(6); drained("R5");
        cur_req = "R5"; service(1, 1, 0, 0, 3); idle(10); drained("R5");
        // R6 one-shot: long quiet window after a pulse
        cur_req = "R6"; service(1, 1, 0, 1, 1); idle(40); drained("R6");
        // R2 each condition missing
        cur_req = "R2"; service(1, 1, 1, 1, 0); idle(20); drained("R2");
        cur_req = "R2"; service(1, 0, 0, 1, 0); idle(20); drained("R2");
        cur_req = "R2"; service(0, 1, 0, 1, 0); tmo_en = 1'b1; idle(20); drained("R2");
        // R7 restart mid-count and stop
        cur_req = "R7"; service(1, 1, 0, 4, 1); idle(4);
        service(1, 1, 0, 4, 1); idle(20); drained("R7");
        cur_req = "R7"; service(1, 1, 0, 4, 1); idle(3);
        service(1, 1, 1, 4, 1); idle(20); drained("R7");
        // R8 enable cleared before expiry, then set again
        cur_req = "R8"; service(1, 1, 0, 3, 1);
        tmo_en = 1'b0; exp_q.delete(); idle(10);
        tmo_en = 1'b1; idle(20); drained("R8");
        // R9 service on the expiry edge: armed edge a, expiry edge a+2
        cur_req = "R9"; service(1, 1, 0, 2, 0);
        service(1, 1, 0, 2, 0); idle(10); drained("R9");
        // R10 field changes after arming ignored
        cur_req = "R10"; service(1, 1, 0, 2, 1);
        tmo_count = CW'(9); presc_div = PW'(7); idle(15); drained("R10");
      end
      begin
        repeat (200000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule